// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block merges five internal event sources into one active-low interrupt request. The sources are timer A underflow, timer B underflow, time-of-day alarm, serial byte done, and a falling edge on an external attention line. Each event sets a latched pending flag, whether or not that source is enabled. A separate enable mask decides which pending flags may pull the request line low.

Software reaches the block through a single register address, and a read means something different from a write. A read returns the pending flags and a summary bit, then clears them all. A write never touches the flags. It updates the mask through a set/clear protocol: the top bit of the written byte decides whether each 1-bit in the low field enables or disables the matching source. The mask itself cannot be read back. Its effect shows only on the request line and in the summary bit.

The four internal sources arrive as one-cycle strobes. The attention line is a level input, and the block detects its high-to-low transitions itself.

Top module: `irq_hub`

## Requirements
- R1: Pending flag positions in read data are fixed: bit 0 timer A underflow (`ev_strobe[0]`), bit 1 timer B underflow (`ev_strobe[1]`), bit 2 alarm (`ev_strobe[2]`), bit 3 serial byte done (`ev_strobe[3]`), bit 4 attention line falling edge.
- R2: A strobe sets its pending flag at the next clock edge even when that source is disabled in the mask; a disabled flag leaves `irq_n` high.
- R3: A read (`rd_en` high for one cycle) returns the current flags on `rd_data` in that cycle; at the following edge all flags and the summary bit clear, so an immediate second read returns 0x00.
- R4: A write with `wr_data[7]` = 1 enables every source whose bit among `wr_data[4:0]` is 1.
- R5: A write with `wr_data[7]` = 0 disables every source whose bit among `wr_data[4:0]` is 1; sources whose written bit is 0 keep their mask state in both write modes.
- R6: `wr_data[6:5]` have no effect on the mask, and `rd_data[6:5]` always read 0.
- R7: `rd_data[7]` reads 1 when an enabled flag has been pending at any time since the last read. It stays 1 even if that source is disabled again before the read.
- R8: Only a high-to-low transition of `flag_n` sets flag bit 4; a held low level or a rising edge sets nothing.
- R9: `irq_n` is low exactly while some pending flag is also enabled, and it returns high after the clearing read.
- R10: A strobe that arrives in the same cycle as a read is not lost. It is absent from that read's data and present in the next read.
- R11: Synchronous reset clears the mask and all flags: `irq_n` is high, a read returns 0x00, and a strobe after reset does not pull `irq_n` low.
- R12: The mask is not visible in read data: with no events pending, a read returns 0x00 whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a mask update |
| wr_data | input | 8 | Write value: bit 7 selects set/clear, bits 4:0 select sources |
| rd_en | input | 1 | Read strobe; clears flags at the end of the cycle |
| rd_data | output | 8 | Summary bit 7, zeros in 6:5, pending flags in 4:0 |
| ev_strobe | input | 4 | One-cycle event strobes for sources 0 to 3 |
| flag_n | input | 1 | External attention line, falling edge is an event |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The mask cannot be read, so a wrong mask bit shows up only through `irq_n` and the summary bit. It appears one cycle after the next strobe of the affected source. For that reason the bench follows every mask update with a strobe and watches the request line. A flag that fails to clear, or an event lost to a read, appears in the data of the very next read; back-to-back reads expose it within two cycles. A wrong summary register stays hidden until a source is disabled between its event and the read, so that ordering is tested on purpose.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int NSRC    = 5;
    localparam int DW      = 8;
    localparam int SUM_BIT = DW - 1;
    localparam int NSTRB   = NSRC - 1;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic {
        MASK_CLEAR = 1'b0,
        MASK_SET   = 1'b1
    } mask_op_e;

    typedef struct packed {
        mask_op_e op;
        src_vec_t sel;
    } mask_cmd_t;

    function automatic mask_cmd_t make_cmd(logic op_bit, src_vec_t sel);
        mask_cmd_t c;
        c.op  = op_bit ? MASK_SET : MASK_CLEAR;
        c.sel = sel;
        return c;
    endfunction

    function automatic src_vec_t apply_cmd(src_vec_t cur, mask_cmd_t c);
        if (c.op == MASK_SET)
            return cur | c.sel;
        return cur & ~c.sel;
    endfunction

    function automatic logic [DW-1:0] pack_read(src_vec_t f, logic summary);
        logic [DW-1:0] r;
        r            = '0;
        r[NSRC-1:0]  = f;
        r[SUM_BIT]   = summary;
        return r;
    endfunction

endpackage

// File: rtl/irq_hub_edge.sv
module irq_hub_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= line_n;
    end

    assign fall = prev_q & ~line_n;

endmodule

// File: rtl/irq_hub_flags.sv
module irq_hub_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)      flags_q[i] <= 1'b0;
            else if (ev[i]) flags_q[i] <= 1'b1;
            else if (clr)   flags_q[i] <= 1'b0;
        end
    end

    assign flags = flags_q;

    // R3
    clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && ev == '0) |=> (flags_q == '0));

    // R2
    event_latched_chk: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((flags_q & $past(ev)) == $past(ev)));

endmodule

// File: rtl/irq_hub_mask.sv
module irq_hub_mask
    import irq_hub_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  mask_cmd_t cmd,
    output src_vec_t  mask
);
    src_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)     mask_q <= '0;
        else if (wr) mask_q <= apply_cmd(mask_q, cmd);
    end

    assign mask = mask_q;

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && cmd.op == MASK_SET) |=> ((mask_q & $past(cmd.sel)) == $past(cmd.sel)));

    // R5
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && cmd.op == MASK_CLEAR) |=> ((mask_q & $past(cmd.sel)) == '0));

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> ((mask_q & ~$past(cmd.sel)) == ($past(mask_q) & ~$past(cmd.sel))));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [NSTRB-1:0] ev_strobe,
    input  logic          flag_n,
    output logic          irq_n
);
    logic      line_fall;
    src_vec_t  ev_all;
    src_vec_t  flags;
    src_vec_t  mask;
    mask_cmd_t cmd;
    logic      active;
    logic      seen_q;
    logic      unused_wr_bits;

    irq_hub_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_n (flag_n),
        .fall   (line_fall)
    );

    assign ev_all = {line_fall, ev_strobe};

    irq_hub_flags #(.N(NSRC)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev_all),
        .clr   (rd_en),
        .flags (flags)
    );

    assign cmd            = make_cmd(wr_data[SUM_BIT], wr_data[NSRC-1:0]);
    assign unused_wr_bits = ^wr_data[SUM_BIT-1:NSRC];

    irq_hub_mask u_mask (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr_en),
        .cmd  (cmd),
        .mask (mask)
    );

    assign active = |(flags & mask);

    always_ff @(posedge clk) begin
        if (rst)        seen_q <= 1'b0;
        else if (rd_en) seen_q <= 1'b0;
        else if (active) seen_q <= 1'b1;
    end

    assign rd_data = pack_read(flags, seen_q | active);
    assign irq_n   = ~active;

    // R9
    req_summary_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> rd_data[SUM_BIT]);

    // R6
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[SUM_BIT-1:NSRC] == '0);

    // R7
    summary_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!irq_n) && !$past(rd_en)) |-> rd_data[SUM_BIT]);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (irq_n && rd_data == '0));

endmodule

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] ev_strobe = 4'h0;
    logic       flag_n = 1'b1;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .ev_strobe (ev_strobe),
        .flag_n    (flag_n),
        .irq_n     (irq_n)
    );

    // monitor: pops one expected read value per read cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected read: actual %02h expected none", rd_data);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rd_data !== e) begin
                        errors++;
                        $display("FAIL %s read: actual %02h expected %02h", t, rd_data, e);
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe(input logic [3:0] v);
        tick();
        ev_strobe = v;
        tick();
        ev_strobe = 4'h0;
    endtask

    task automatic wr(input logic [7:0] d);
        tick();
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic rd(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        tick();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq_n !== e) begin
            errors++;
            $display("FAIL %s irq_n: actual %0b expected %0b", t, irq_n, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;

        // R11 reset state
        check_irq(1'b1, "R11");
        rd(8'h00, "R11");

        // R2 disabled source still latches, no request
        strobe(4'b0001);
        check_irq(1'b1, "R2");
        rd(8'h01, "R2");
        rd(8'h00, "R3");

        // R1 bit positions
        strobe(4'b0010); rd(8'h02, "R1");
        strobe(4'b0100); rd(8'h04, "R1");
        strobe(4'b1000); rd(8'h08, "R1");

        // R8 attention line edges
        tick(); flag_n = 1'b0;
        tick();
        rd(8'h10, "R8");
        repeat (3) tick();
        rd(8'h00, "R8");
        tick(); flag_n = 1'b1;
        repeat (2) tick();
        rd(8'h00, "R8");

        // R4 / R12 set protocol, mask invisible
        wr(8'h81);
        rd(8'h00, "R12");
        check_irq(1'b1, "R4");
        strobe(4'b0001);
        check_irq(1'b0, "R4");
        rd(8'h81, "R7");
        check_irq(1'b1, "R9");

        // R5 clear protocol, zero bits keep
        wr(8'hFF);
        wr(8'h01);
        strobe(4'b0010);
        check_irq(1'b0, "R5");
        rd(8'h82, "R5");
        strobe(4'b0001);
        check_irq(1'b1, "R5");
        rd(8'h01, "R5");

        // R6 spare write bits ignored
        wr(8'h60);
        wr(8'hE0);
        strobe(4'b0100);
        check_irq(1'b0, "R6");
        rd(8'h84, "R6");

        // R7 summary sticky after disabling the source
        strobe(4'b1000);
        check_irq(1'b0, "R9");
        wr(8'h08);
        check_irq(1'b1, "R7");
        rd(8'h88, "R7");
        rd(8'h00, "R7");

        // R10 event coinciding with read
        strobe(4'b0001);
        check_irq(1'b1, "R10");
        exp_q.push_back(8'h01);
        tag_q.push_back("R10");
        tick();
        rd_en = 1'b1;
        ev_strobe = 4'b0010;
        tick();
        rd_en = 1'b0;
        ev_strobe = 4'h0;
        rd(8'h82, "R10");

        // R11 reset in the middle of activity
        wr(8'h9F);
        strobe(4'b0001);
        check_irq(1'b0, "R11");
        tick(); rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        check_irq(1'b1, "R11");
        rd(8'h00, "R11");
        strobe(4'b0001);
        check_irq(1'b1, "R11");
        rd(8'h01, "R11");

        repeat (3) tick();
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL pending reads: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule